// File: doc/BRIEF.md
# Fractional Line and Frame Timer

This block derives horizontal-line and frame timing from a free-running system clock for a video subsystem. The average line length is a fractional number of clocks, so the block does not use an integer divider. A 32-bit fixed-point accumulator with 12 fractional bits keeps the position where the current line started. A line ends when a free-running clock counter reaches the integer part of that position plus the per-region increment.

A region input selects 60 Hz timing (263 lines per frame) or 50 Hz timing (313 lines per frame). Each region has its own increment. The block counts lines within the frame and marks the start of vertical blanking at line 240. It also marks the return to line 0 at the end of each frame. An odd/even field bit toggles once per frame while interlace is on. The block issues a sound-sync tick on every 32nd line, counted without regard to frame edges. A 32-bit status word packs the field bit, a display-active flag and the line number for other logic to read.

Top module: `line_frame_timer`

## Requirements
- R1: While reset is held, and after its release until the first line boundary, `line_num` is 0. `line_tick`, `vblank_start`, `frame_pulse`, `snd_tick` and `field_odd` are 0, and `status_word` is 0x4000_0000. The latched region is 60 Hz and the accumulator and clock counter are 0.
- R2: Let `inc` be 8791293 for 60 Hz or 8864320 for 50 Hz, and let `acc` be the accumulator. A line boundary happens in the cycle where the clock counter (the number of rising edges since reset release) equals bits [31:12] of `acc + inc`. In that cycle, `acc + inc` replaces `acc`, with 32-bit wraparound. `line_tick` is high for exactly the one cycle after each boundary.
- R3: `line_num` changes only together with `line_tick`. At each boundary it increments, except after the last line of the frame (262 for 60 Hz, 313 − 1 = 312 for 50 Hz), where it returns to 0.
- R4: `region_sel` = 0 selects 60 Hz and 1 selects 50 Hz. The block samples it only at the boundary that ends a frame, and the sampled value sets the line count and increment of the next frame.
- R5: `vblank_start` is high for one cycle, together with the `line_tick` at which `line_num` becomes 240.
- R6: `frame_pulse` is high for one cycle, together with the `line_tick` at which `line_num` returns to 0.
- R7: `snd_tick` is high together with `line_tick` on every 32nd line boundary, counted from reset without regard to frames, in both regions.
- R8: At each frame-ending boundary, `field_odd` toggles if `interlace_en` is 1 and is cleared if `interlace_en` is 0. It does not change at any other time.
- R9: The fields of `status_word` are as follows. Bit 31 equals `field_odd`. Bit 30 is a display-active flag: it is set by reset and at each frame start, and cleared together with `vblank_start`. Bits [LINE_W-1:0] hold `line_num`, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| region_sel | input | 1 | 0 = 60 Hz timing, 1 = 50 Hz timing |
| interlace_en | input | 1 | Enables the per-frame field toggle |
| line_tick | output | 1 | One-cycle pulse after each line boundary |
| line_num | output | LINE_W | Current line within the frame |
| vblank_start | output | 1 | One-cycle pulse as the line reaches the vertical blank line |
| frame_pulse | output | 1 | One-cycle pulse as the line returns to 0 |
| field_odd | output | 1 | Odd/even field bit |
| snd_tick | output | 1 | One-cycle pulse on every group of lines |
| status_word | output | 32 | Field bit, display-active flag and line number |

## Verification
The block detects a boundary in the cycle where the clock counter matches the integer part of the next accumulator value. Every output is a register, so every result appears exactly one rising edge later. The bench samples outputs at the falling edge after each rising edge. It recomputes the boundary clock as (acc + inc) >> 12 from its own accumulator, which it advances with the same sampled inputs the design sees at that edge, and it compares every output on every cycle. The bench changes region and interlace inputs only at falling edges. The model therefore knows which values are latched at a frame-ending edge. The runs use a reduced line count and increment, so many frames, region switches, wraps of the sound group and a mid-run reset fit in the run.

// File: rtl/lft_pkg.sv
`timescale 1ns/1ps
package lft_pkg;

  typedef enum logic {
    REGION_60 = 1'b0,
    REGION_50 = 1'b1
  } region_e;

  // Number of lines in a frame for the selected region.
  function automatic int unsigned frame_lines(region_e r, int unsigned l60, int unsigned l50);
    return (r == REGION_50) ? l50 : l60;
  endfunction

  // Increment per line for the selected region (fixed point).
  function automatic int unsigned line_inc(region_e r, int unsigned i60, int unsigned i50);
    return (r == REGION_50) ? i50 : i60;
  endfunction

endpackage

// File: rtl/lft_phase_acc.sv
`timescale 1ns/1ps
module lft_phase_acc #(
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned FRAC_BITS = 12,
  parameter int unsigned INC_60    = 8791293,
  parameter int unsigned INC_50    = 8864320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lft_pkg::region_e  region_q,
  output logic              line_end
);
  localparam int unsigned IW = ACC_W - FRAC_BITS;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_sel;
  logic [ACC_W-1:0] acc_next;
  logic [IW-1:0]    clk_cnt_q;

  always_comb begin
    inc_sel  = ACC_W'(lft_pkg::line_inc(region_q, INC_60, INC_50));
    acc_next = acc_q + inc_sel;
    line_end = (clk_cnt_q == acc_next[ACC_W-1:FRAC_BITS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      clk_cnt_q <= '0;
    end else begin
      clk_cnt_q <= clk_cnt_q + 1'b1;
      if (line_end) acc_q <= acc_next;
    end
  end
endmodule

// File: rtl/lft_line_seq.sv
`timescale 1ns/1ps
module lft_line_seq #(
  parameter int unsigned LINE_W      = 9,
  parameter int unsigned LINES_60    = 263,
  parameter int unsigned LINES_50    = 313,
  parameter int unsigned VBLANK_LINE = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              region_sel,
  input  logic              interlace_en,
  output logic              line_tick,
  output logic [LINE_W-1:0] line_num,
  output logic              vblank_start,
  output logic              frame_pulse,
  output logic              field_odd,
  output logic              active,
  output lft_pkg::region_e  region_q
);
  localparam logic [LINE_W-1:0] VB_PREV = LINE_W'(VBLANK_LINE - 1);

  logic [LINE_W-1:0] last_line;
  logic              at_last;

  always_comb begin
    last_line = LINE_W'(lft_pkg::frame_lines(region_q, LINES_60, LINES_50) - 1);
    at_last   = (line_num == last_line);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_tick    <= 1'b0;
      line_num     <= '0;
      vblank_start <= 1'b0;
      frame_pulse  <= 1'b0;
      field_odd    <= 1'b0;
      active       <= 1'b1;
      region_q     <= lft_pkg::REGION_60;
    end else begin
      line_tick    <= line_end;
      vblank_start <= 1'b0;
      frame_pulse  <= 1'b0;
      if (line_end) begin
        if (at_last) begin
          line_num    <= '0;
          frame_pulse <= 1'b1;
          active      <= 1'b1;
          region_q    <= lft_pkg::region_e'(region_sel);
          field_odd   <= interlace_en ? ~field_odd : 1'b0;
        end else begin
          line_num <= line_num + 1'b1;
          if (line_num == VB_PREV) begin
            vblank_start <= 1'b1;
            active       <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lft_group_div.sv
`timescale 1ns/1ps
module lft_group_div #(
  parameter int unsigned GROUP = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_end,
  output logic grp_tick
);
  localparam int unsigned GW = (GROUP > 2) ? $clog2(GROUP) : 1;

  logic [GW-1:0] cnt_q;
  logic          wrap;

  generate
    if ((GROUP & (GROUP - 1)) == 0) begin : g_pow2
      // Power of two: the counter wraps by itself.
      assign wrap = &cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (line_end) cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_mod
      assign wrap = (cnt_q == GW'(GROUP - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (line_end) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_tick <= 1'b0;
    else        grp_tick <= line_end & wrap;
  end
endmodule

// File: rtl/line_frame_timer.sv
`timescale 1ns/1ps
module line_frame_timer #(
  parameter int unsigned ACC_W       = 32,
  parameter int unsigned FRAC_BITS   = 12,
  parameter int unsigned INC_60      = 8791293,
  parameter int unsigned INC_50      = 8864320,
  parameter int unsigned LINES_60    = 263,
  parameter int unsigned LINES_50    = 313,
  parameter int unsigned VBLANK_LINE = 240,
  parameter int unsigned SND_GROUP   = 32,
  parameter int unsigned LINE_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              region_sel,
  input  logic              interlace_en,
  output logic              line_tick,
  output logic [LINE_W-1:0] line_num,
  output logic              vblank_start,
  output logic              frame_pulse,
  output logic              field_odd,
  output logic              snd_tick,
  output logic [31:0]       status_word
);
  localparam int unsigned PAD_W = 30 - LINE_W;

  // Internal events, named for the checker.
  logic             line_end;
  logic             active;
  lft_pkg::region_e region_q;

  lft_phase_acc #(
    .ACC_W(ACC_W), .FRAC_BITS(FRAC_BITS), .INC_60(INC_60), .INC_50(INC_50)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .region_q(region_q), .line_end(line_end)
  );

  lft_line_seq #(
    .LINE_W(LINE_W), .LINES_60(LINES_60), .LINES_50(LINES_50), .VBLANK_LINE(VBLANK_LINE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .region_sel(region_sel),
    .interlace_en(interlace_en), .line_tick(line_tick), .line_num(line_num),
    .vblank_start(vblank_start), .frame_pulse(frame_pulse), .field_odd(field_odd),
    .active(active), .region_q(region_q)
  );

  lft_group_div #(.GROUP(SND_GROUP)) u_grp (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .grp_tick(snd_tick)
  );

  assign status_word = {field_odd, active, {PAD_W{1'b0}}, line_num};
endmodule

// File: rtl/line_frame_timer_chk.sv
`timescale 1ns/1ps
module line_frame_timer_chk #(
  parameter int unsigned LINES_60    = 263,
  parameter int unsigned LINES_50    = 313,
  parameter int unsigned VBLANK_LINE = 240,
  parameter int unsigned LINE_W      = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_tick,
  input logic [LINE_W-1:0] line_num,
  input logic              vblank_start,
  input logic              frame_pulse,
  input logic              snd_tick,
  input logic              field_odd,
  input logic [31:0]       status_word,
  input logic              region_q
);
  localparam int unsigned MAXL = (LINES_60 > LINES_50) ? LINES_60 : LINES_50;

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> !line_tick);

  assert_line_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num != $past(line_num)) |-> line_tick);

  assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(line_num) < MAXL);

  assert_region_at_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (region_q != $past(region_q)) |-> frame_pulse);

  assert_vblank_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |-> (line_tick && 32'(line_num) == VBLANK_LINE));

  assert_frame_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (line_tick && line_num == '0));

  assert_snd_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snd_tick |-> line_tick);

  assert_field_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (field_odd != $past(field_odd)) |-> frame_pulse);

  assert_active_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |-> !status_word[30]);
endmodule

bind line_frame_timer line_frame_timer_chk #(
  .LINES_60(LINES_60), .LINES_50(LINES_50), .VBLANK_LINE(VBLANK_LINE), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .line_num(line_num),
  .vblank_start(vblank_start), .frame_pulse(frame_pulse), .snd_tick(snd_tick),
  .field_odd(field_odd), .status_word(status_word), .region_q(region_q)
);

// File: tb/test_line_frame_timer.sv
`timescale 1ns/1ps
module test_line_frame_timer;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned T_INC60 = 22000;
  localparam int unsigned T_INC50 = 27000;
  localparam int unsigned T_L60   = 7;
  localparam int unsigned T_L50   = 9;
  localparam int unsigned T_VBL   = 5;
  localparam int unsigned T_GRP   = 4;
  localparam int unsigned T_LW    = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic region_sel = 1'b0;
  logic interlace_en = 1'b0;
  logic line_tick, vblank_start, frame_pulse, field_odd, snd_tick;
  logic [T_LW-1:0] line_num;
  logic [31:0] status_word;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench model state
  longint m_acc, e;
  int unsigned m_line, m_grp;
  bit m_rq, m_field, m_active;
  bit x_tick, x_vb, x_fr, x_snd;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_frame_timer #(
    .INC_60(T_INC60), .INC_50(T_INC50), .LINES_60(T_L60), .LINES_50(T_L50),
    .VBLANK_LINE(T_VBL), .SND_GROUP(T_GRP), .LINE_W(T_LW)
  ) i_line_frame_timer (
    .clk(clk), .rst_n(rst_n), .region_sel(region_sel), .interlace_en(interlace_en),
    .line_tick(line_tick), .line_num(line_num), .vblank_start(vblank_start),
    .frame_pulse(frame_pulse), .field_odd(field_odd), .snd_tick(snd_tick),
    .status_word(status_word)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at edge %0d", req, act, exp, e);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; e = 0; m_line = 0; m_grp = 0;
    m_rq = 1'b0; m_field = 1'b0; m_active = 1'b1;
  endtask

  function automatic logic [31:0] exp_status();
    return {m_field, m_active, 30'(m_line)};
  endfunction

  // R1: reset values
  task automatic check_reset_state(string tag);
    check({tag, " R1 line_num"}, 32'(line_num), 32'd0);
    check({tag, " R1 pulses"}, {28'd0, line_tick, vblank_start, frame_pulse, snd_tick}, 32'd0);
    check({tag, " R1 field"}, 32'(field_odd), 32'd0);
    check({tag, " R1 status"}, status_word, 32'h4000_0000);
  endtask

  // One rising edge, then model update with the inputs present at that edge.
  task automatic step();
    longint inc, bnd;
    int unsigned lines;
    @(posedge clk);
    @(negedge clk);
    e++;
    x_tick = 0; x_vb = 0; x_fr = 0; x_snd = 0;
    inc   = m_rq ? longint'(T_INC50) : longint'(T_INC60);
    lines = m_rq ? T_L50 : T_L60;
    bnd   = (m_acc + inc) >> 12;
    if (e - 1 == bnd) begin
      x_tick = 1;
      m_acc += inc;
      if (m_grp == T_GRP - 1) begin m_grp = 0; x_snd = 1; end
      else m_grp++;
      if (m_line == lines - 1) begin
        m_line = 0; x_fr = 1; m_active = 1'b1;
        m_rq = region_sel;
        m_field = interlace_en ? ~m_field : 1'b0;
      end else begin
        m_line++;
        if (m_line == T_VBL) begin x_vb = 1; m_active = 1'b0; end
      end
    end
    check("R2 line_tick", 32'(line_tick), 32'(x_tick));
    check("R3 line_num", 32'(line_num), 32'(m_line));
    check("R5 vblank_start", 32'(vblank_start), 32'(x_vb));
    check("R6 frame_pulse", 32'(frame_pulse), 32'(x_fr));
    check("R7 snd_tick", 32'(snd_tick), 32'(x_snd));
    check("R8 field_odd", 32'(field_odd), 32'(m_field));
    check("R9 status_word", status_word, exp_status());
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_state("in reset");
    rst_n = 1'b1;
    check_reset_state("after release");

    // Phase A: 60 Hz, progressive (R2, R3, R5, R6, R7)
    for (int i = 0; i < 300; i++) step();

    // Phase B: switch to 50 Hz mid-frame, interlace on (R4, R8)
    region_sel = 1'b1; interlace_en = 1'b1;
    for (int i = 0; i < 400; i++) step();

    // Phase C: inputs toggling at odd intervals (R4, R8)
    for (int i = 0; i < 900; i++) begin
      if (i % 37 == 0) region_sel = ~region_sel;
      if (i % 53 == 0) interlace_en = ~interlace_en;
      step();
    end

    // Mid-run reset, then 50 Hz requested from the start: first frame stays 60 Hz (R1, R4)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("mid-run reset");
    model_reset();
    region_sel = 1'b1; interlace_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    check_reset_state("after second release");
    for (int i = 0; i < 300; i++) step();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule